// File: doc/BRIEF.md
# Self-Checking Configuration Register Bank

This block holds a small set of device configuration registers. After reset, a startup sequencer copies them one at a time from the non-volatile configuration words. Each transfer is a single beat on the load port. The beat carries the target index, the register value, the stored complement image of that value and the stored parity bit for it. All three are captured in the same cycle, so a correctly programmed word never looks inconsistent while loading is under way.

The sequencer raises a load-done signal when the copy is complete. From then on the bank arms its checking and stops accepting loads. Two checks run on every slot on every cycle:

- a comparison of the live value against its complement copy;
- a recomputation of the value's parity against the stored bit.

Any failure latches a fault that stays set until the next reset. A two-bit cause vector records which kind of check failed. A one-cycle reset request goes to the reset controller at the moment the fault first appears. The live values are presented as one flat bus for the rest of the chip.

Top module: `cfg_guard_bank`

## Requirements
- R1: After reset, every slot reads zero on `cfg_out`, and `fault`, `fault_cause` and `reset_req` are all zero. Each slot's complement copy resets to all ones and its parity bit resets to zero, so the reset state is consistent.
- R2: While checking is not armed, a cycle with `ld_valid` high writes `ld_value`, `ld_shadow` and `ld_parity` into the slot selected by `ld_index`. The new value appears on `cfg_out[ld_index*WIDTH +: WIDTH]` after that clock edge, and every other slot is left unchanged.
- R3: A clock edge with `ld_done` high arms checking, and checking stays armed until reset. A load in the same cycle as `ld_done` is still accepted. Every load beat presented once armed leaves `cfg_out` unchanged.
- R4: While checking is not armed, no fault is reported, even if a slot holds an inconsistent value, complement or parity.
- R5: Once armed, if any slot's value differs from the bitwise complement of its stored copy, `fault_cause[0]` (complement mismatch) is set after the next clock edge. This holds even when only one bit position differs.
- R6: Once armed, if any slot's stored parity bit differs from the XOR of all its value bits, `fault_cause[1]` (parity failure) is set after the next clock edge.
- R7: `fault` is high exactly when at least one cause bit is set. `fault` and every set cause bit hold until reset. Failures of both kinds set both cause bits.
- R8: `reset_req` is high for exactly one cycle, the first cycle in which `fault` is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ld_valid | input | 1 | Load beat present this cycle |
| ld_index | input | IDXW | Slot number for the load beat |
| ld_value | input | WIDTH | Configuration value from the non-volatile word |
| ld_shadow | input | WIDTH | Stored complement image of the value |
| ld_parity | input | 1 | Stored parity bit (XOR of the value bits) |
| ld_done | input | 1 | Startup copy complete; arms checking |
| cfg_out | output | NREG*WIDTH | Live values, slot n at bits n*WIDTH upward |
| fault | output | 1 | Sticky integrity fault |
| fault_cause | output | 2 | Bit 0: complement mismatch; bit 1: parity failure |
| reset_req | output | 1 | One-cycle device reset request |

## Verification
The load path is driven from a table of index/value pairs that includes overwrites, an all-ones word, an all-zeros word and words with only the end bits set. This separates correct slot selection from leakage into neighbouring slots. Integrity checking is tried with four kinds of input:

- a wrong complement loaded before arming, then repaired before arming, which shows that checking waits for load-done;
- load beats after arming, which shows the lock;
- a single corrupted complement bit at low, middle and top positions, which shows per-bit comparison;
- a bad parity bit alone and combined with a complement error, which shows that the cause bits are kept apart.

The exact cycle of the one-shot reset request is sampled at every fault.

// File: rtl/cfg_guard_pkg.sv
// Package cfg_guard_pkg
// Shared definitions for the self-checking configuration bank:
// positions of the fault-cause bits and the per-cycle error summary.
// Assumes nothing beyond IEEE 1800-2017.
package cfg_guard_pkg;

    localparam int CAUSE_W      = 2;
    localparam int CAUSE_SHADOW = 0;
    localparam int CAUSE_PARITY = 1;

    typedef struct packed {
        logic parity_bad;
        logic shadow_bad;
    } chk_err_t;

endpackage

// File: rtl/cfg_reg_slot.sv
// Module cfg_reg_slot
// One protected configuration register: live value, complement copy and
// stored parity bit, all written together from the load port while the
// bank is not armed. It reports, every cycle, whether the value disagrees
// with its complement copy and whether its parity disagrees with the
// stored bit.
// Assumes: SLOT_ID < 2**IDXW; synchronous active-low reset.
module cfg_reg_slot #(
    parameter int WIDTH   = 16,
    parameter int IDXW    = 2,
    parameter int SLOT_ID = 0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ld_valid,
    input  logic [IDXW-1:0]  ld_index,
    input  logic [WIDTH-1:0] ld_value,
    input  logic [WIDTH-1:0] ld_shadow,
    input  logic             ld_parity,
    input  logic             armed,
    output logic [WIDTH-1:0] value,
    output logic             shadow_err,
    output logic             parity_err
);

    localparam logic [IDXW-1:0] MY_IDX = IDXW'(SLOT_ID);

    logic [WIDTH-1:0] value_q;
    logic [WIDTH-1:0] shadow_q;
    logic             parity_q;
    logic             wr_en;

    // Accept a load beat only for this slot and only before arming.
    assign wr_en = ld_valid && !armed && (ld_index == MY_IDX);

    // Capture value, complement and parity in one cycle; reset is consistent.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            value_q  <= '0;
            shadow_q <= '1;
            parity_q <= 1'b0;
        end else if (wr_en) begin
            value_q  <= ld_value;
            shadow_q <= ld_shadow;
            parity_q <= ld_parity;
        end
    end

    // Continuous integrity comparison of the stored triple.
    always_comb begin
        shadow_err = (value_q != ~shadow_q);
        parity_err = ((^value_q) != parity_q);
    end

    assign value = value_q;

endmodule

// File: rtl/cfg_fault_ctrl.sv
// Module cfg_fault_ctrl
// Arms integrity checking on load-done and latches per-cause fault bits
// from the slot error vectors. It raises a one-cycle reset request on the
// first detection. Fault and cause bits are sticky until reset.
// Assumes: error inputs are combinational from registered state.
module cfg_fault_ctrl
    import cfg_guard_pkg::*;
#(
    parameter int NREG = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               ld_done,
    input  logic [NREG-1:0]    shadow_err_v,
    input  logic [NREG-1:0]    parity_err_v,
    output logic               armed,
    output logic               fault,
    output logic [CAUSE_W-1:0] fault_cause,
    output logic               reset_req
);

    chk_err_t           err_now;
    logic               any_err;
    logic               armed_q;
    logic               fault_q;
    logic               req_q;
    logic [CAUSE_W-1:0] cause_q;

    // Reduce the per-slot errors to one summary for this cycle.
    always_comb begin
        err_now.shadow_bad = |shadow_err_v;
        err_now.parity_bad = |parity_err_v;
        any_err            = err_now.shadow_bad | err_now.parity_bad;
    end

    // Arming flag: set by load-done, held until reset.
    always_ff @(posedge clk) begin
        if (!rst_n)       armed_q <= 1'b0;
        else if (ld_done) armed_q <= 1'b1;
    end

    // Sticky cause bits and fault flag, updated only once armed.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cause_q <= '0;
            fault_q <= 1'b0;
        end else if (armed_q) begin
            cause_q[CAUSE_SHADOW] <= cause_q[CAUSE_SHADOW] | err_now.shadow_bad;
            cause_q[CAUSE_PARITY] <= cause_q[CAUSE_PARITY] | err_now.parity_bad;
            fault_q               <= fault_q | any_err;
        end
    end

    // One-shot reset request on the first detected failure.
    always_ff @(posedge clk) begin
        if (!rst_n) req_q <= 1'b0;
        else        req_q <= armed_q && any_err && !fault_q;
    end

    assign armed       = armed_q;
    assign fault       = fault_q;
    assign fault_cause = cause_q;
    assign reset_req   = req_q;

endmodule

// File: rtl/cfg_guard_bank.sv
// Module cfg_guard_bank
// Top of the self-checking configuration register bank. NREG slots, each
// WIDTH bits, are loaded from the startup sequencer and then locked. Each
// slot is guarded by a complement copy and a parity bit, and a shared
// controller latches faults and requests a device reset.
// Assumes: NREG >= 2; ld_index values >= NREG select no slot.
module cfg_guard_bank
    import cfg_guard_pkg::*;
#(
    parameter int NREG  = 4,
    parameter int WIDTH = 16,
    parameter int IDXW  = $clog2(NREG)
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  ld_valid,
    input  logic [IDXW-1:0]       ld_index,
    input  logic [WIDTH-1:0]      ld_value,
    input  logic [WIDTH-1:0]      ld_shadow,
    input  logic                  ld_parity,
    input  logic                  ld_done,
    output logic [NREG*WIDTH-1:0] cfg_out,
    output logic                  fault,
    output logic [CAUSE_W-1:0]    fault_cause,
    output logic                  reset_req
);

    logic [NREG-1:0] shadow_err_v;
    logic [NREG-1:0] parity_err_v;
    logic            armed;

    // One protected slot per configuration register.
    for (genvar g = 0; g < NREG; g++) begin : g_slot
        cfg_reg_slot #(
            .WIDTH   (WIDTH),
            .IDXW    (IDXW),
            .SLOT_ID (g)
        ) u_slot (
            .clk        (clk),
            .rst_n      (rst_n),
            .ld_valid   (ld_valid),
            .ld_index   (ld_index),
            .ld_value   (ld_value),
            .ld_shadow  (ld_shadow),
            .ld_parity  (ld_parity),
            .armed      (armed),
            .value      (cfg_out[g*WIDTH +: WIDTH]),
            .shadow_err (shadow_err_v[g]),
            .parity_err (parity_err_v[g])
        );
    end

    cfg_fault_ctrl #(
        .NREG (NREG)
    ) u_ctrl (
        .clk          (clk),
        .rst_n        (rst_n),
        .ld_done      (ld_done),
        .shadow_err_v (shadow_err_v),
        .parity_err_v (parity_err_v),
        .armed        (armed),
        .fault        (fault),
        .fault_cause  (fault_cause),
        .reset_req    (reset_req)
    );

endmodule

// File: rtl/cfg_guard_bank_chk.sv
// Module cfg_guard_bank_chk
// Assertion checker for cfg_guard_bank, attached by bind. It relates the
// slot error vectors, arming state and controller outputs over time.
// Assumes: synchronous active-low reset; all properties are disabled in reset.
module cfg_guard_bank_chk #(
    parameter int NREG  = 4,
    parameter int WIDTH = 16
) (
    input logic                  clk,
    input logic                  rst_n,
    input logic                  armed,
    input logic [NREG*WIDTH-1:0] cfg_out,
    input logic [NREG-1:0]       shadow_err_v,
    input logic [NREG-1:0]       parity_err_v,
    input logic                  fault,
    input logic [1:0]            fault_cause,
    input logic                  reset_req
);

    assert_load_locked_R3: assert property (@(posedge clk) disable iff (!rst_n)
        armed |=> $stable(cfg_out));

    assert_armed_holds_R3: assert property (@(posedge clk) disable iff (!rst_n)
        armed |=> armed);

    assert_quiet_unarmed_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !armed |-> !fault);

    assert_shadow_flag_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (armed && (|shadow_err_v)) |=> fault_cause[0]);

    assert_parity_flag_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (armed && (|parity_err_v)) |=> fault_cause[1]);

    assert_fault_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
        fault |=> fault);

    assert_cause_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        fault |=> ((fault_cause & $past(fault_cause)) == $past(fault_cause)));

    assert_fault_has_cause_R7: assert property (@(posedge clk) disable iff (!rst_n)
        fault |-> (fault_cause != 2'b00));

    assert_req_single_R8: assert property (@(posedge clk) disable iff (!rst_n)
        reset_req |=> !reset_req);

    assert_req_with_fault_R8: assert property (@(posedge clk) disable iff (!rst_n)
        reset_req |-> fault);

    assert_req_on_rise_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (!fault ##1 fault) |-> reset_req);

endmodule

bind cfg_guard_bank cfg_guard_bank_chk #(
    .NREG  (NREG),
    .WIDTH (WIDTH)
) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .armed        (armed),
    .cfg_out      (cfg_out),
    .shadow_err_v (shadow_err_v),
    .parity_err_v (parity_err_v),
    .fault        (fault),
    .fault_cause  (fault_cause),
    .reset_req    (reset_req)
);

// File: tb/cfg_guard_bank_bench.sv
`timescale 1ns/1ps
module cfg_guard_bank_bench;

    localparam int NREG  = 4;
    localparam int WIDTH = 16;
    localparam int IDXW  = 2;
    localparam int NVEC  = 6;

    // Load vectors: {index, value}; complement and parity are derived here.
    localparam logic [IDXW+WIDTH-1:0] VEC [NVEC] = '{
        {2'd0, 16'h1234},
        {2'd1, 16'hFFFF},
        {2'd2, 16'h0000},
        {2'd3, 16'h8001},
        {2'd1, 16'h5A5A},
        {2'd0, 16'h0F0E}
    };

    logic                  clk = 1'b0;
    logic                  rst_n = 1'b0;
    logic                  ld_valid = 1'b0;
    logic [IDXW-1:0]       ld_index = '0;
    logic [WIDTH-1:0]      ld_value = '0;
    logic [WIDTH-1:0]      ld_shadow = '0;
    logic                  ld_parity = 1'b0;
    logic                  ld_done = 1'b0;
    logic [NREG*WIDTH-1:0] cfg_out;
    logic                  fault;
    logic [1:0]            fault_cause;
    logic                  reset_req;

    int checks = 0;
    int errors = 0;
    logic [WIDTH-1:0] model [NREG];

    always #2.5 clk = ~clk;

    cfg_guard_bank #(.NREG(NREG), .WIDTH(WIDTH)) u_cfg_guard_bank (
        .clk(clk), .rst_n(rst_n), .ld_valid(ld_valid), .ld_index(ld_index),
        .ld_value(ld_value), .ld_shadow(ld_shadow), .ld_parity(ld_parity),
        .ld_done(ld_done), .cfg_out(cfg_out), .fault(fault),
        .fault_cause(fault_cause), .reset_req(reset_req)
    );

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0; ld_valid = 1'b0; ld_done = 1'b0;
        @(negedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        for (int i = 0; i < NREG; i++) model[i] = '0;
    endtask

    // One load beat; returns at the negedge after the capturing edge.
    task automatic load_raw(input logic [IDXW-1:0] idx, input logic [WIDTH-1:0] v,
                            input logic [WIDTH-1:0] sh, input logic par);
        @(negedge clk);
        ld_valid = 1'b1; ld_index = idx; ld_value = v; ld_shadow = sh; ld_parity = par;
        @(negedge clk);
        ld_valid = 1'b0;
    endtask

    task automatic load_good(input logic [IDXW-1:0] idx, input logic [WIDTH-1:0] v);
        load_raw(idx, v, ~v, ^v);
    endtask

    // Pulse load-done; returns at the negedge after the arming edge.
    task automatic finish_load();
        @(negedge clk);
        ld_done = 1'b1;
        @(negedge clk);
        ld_done = 1'b0;
    endtask

    task automatic check_all_slots(input string req);
        for (int i = 0; i < NREG; i++)
            chk(req, 64'(cfg_out[i*WIDTH +: WIDTH]), 64'(model[i]));
    endtask

    // Fault is expected one edge after arming, with a one-cycle reset request.
    task automatic expect_fault(input string req, input logic [1:0] cause);
        chk({req, " no fault before first check"}, 64'(fault), 64'd0);
        @(negedge clk);
        chk({req, " fault"}, 64'(fault), 64'd1);
        chk({req, " cause"}, 64'(fault_cause), 64'(cause));
        chk("R8 reset_req first cycle", 64'(reset_req), 64'd1);
        @(negedge clk);
        chk("R8 reset_req dropped", 64'(reset_req), 64'd0);
        chk("R7 fault sticky", 64'(fault), 64'd1);
        repeat (3) @(negedge clk);
        chk("R7 fault held", 64'(fault), 64'd1);
        chk("R7 cause held", 64'(fault_cause), 64'(cause));
        chk("R8 reset_req stays low", 64'(reset_req), 64'd0);
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin : main
        logic [IDXW-1:0]  vi;
        logic [WIDTH-1:0] vv;
        int               pos [3];

        pos[0] = 0; pos[1] = 7; pos[2] = 15;

        // R1: reset state
        do_reset();
        @(negedge clk);
        chk("R1 cfg_out zero", 64'(cfg_out), 64'd0);
        chk("R1 fault", 64'(fault), 64'd0);
        chk("R1 cause", 64'(fault_cause), 64'd0);
        chk("R1 reset_req", 64'(reset_req), 64'd0);

        // R2: table-driven loads, every slot compared after each beat
        for (int k = 0; k < NVEC; k++) begin
            {vi, vv} = VEC[k];
            load_good(vi, vv);
            model[vi] = vv;
            check_all_slots("R2 load to slot");
        end

        // R4: inconsistent complement before arming raises nothing
        load_raw(2'd2, 16'hC3C3, 16'hC3C3, ^16'hC3C3);
        model[2] = 16'hC3C3;
        repeat (3) @(negedge clk);
        chk("R4 no fault while unarmed", 64'(fault), 64'd0);
        chk("R4 no cause while unarmed", 64'(fault_cause), 64'd0);

        // Repair it, arm; loaded state is consistent so no fault (R5 negative)
        load_good(2'd2, 16'h3C3C);
        model[2] = 16'h3C3C;
        finish_load();
        repeat (3) @(negedge clk);
        chk("R5 consistent bank no fault", 64'(fault), 64'd0);
        chk("R8 no request without fault", 64'(reset_req), 64'd0);

        // R3: load beats once armed are ignored, including a corrupt one
        load_good(2'd0, 16'hBEEF);
        load_raw(2'd3, 16'h0001, 16'h0001, 1'b0);
        repeat (2) @(negedge clk);
        check_all_slots("R3 locked after done");
        chk("R3 ignored beat no fault", 64'(fault), 64'd0);

        // R3: a load in the same cycle as done is still accepted
        do_reset();
        @(negedge clk);
        ld_valid = 1'b1; ld_index = 2'd1; ld_value = 16'h7777;
        ld_shadow = ~16'h7777; ld_parity = ^16'h7777; ld_done = 1'b1;
        @(negedge clk);
        ld_valid = 1'b0; ld_done = 1'b0;
        model[1] = 16'h7777;
        check_all_slots("R3 load with done accepted");
        load_good(2'd1, 16'h1111);
        check_all_slots("R3 locked after same-cycle done");

        // R6: wrong stored parity on one slot
        do_reset();
        load_raw(2'd3, 16'h0001, ~16'h0001, 1'b0);
        finish_load();
        expect_fault("R6 parity", 2'b10);

        // R5: single corrupted complement bit at several positions
        for (int p = 0; p < 3; p++) begin
            do_reset();
            load_raw(2'd1, 16'hA5A5, ~16'hA5A5 ^ (16'h1 << pos[p]), ^16'hA5A5);
            finish_load();
            expect_fault("R5 single-bit complement", 2'b01);
        end

        // R7: both kinds on different slots set both cause bits
        do_reset();
        load_raw(2'd0, 16'h00F0, 16'h00F0, ^16'h00F0);
        load_raw(2'd2, 16'h0003, ~16'h0003, 1'b1);
        finish_load();
        expect_fault("R7 both causes", 2'b11);

        // R1: reset clears a latched fault
        do_reset();
        @(negedge clk);
        chk("R1 fault cleared by reset", 64'(fault), 64'd0);
        chk("R1 cause cleared by reset", 64'(fault_cause), 64'd0);

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule